// File: doc/BRIEF.md
# I2C Slave Address Matcher (7-bit and 10-bit)

This block is the address stage of an I2C slave. A bit-level front end, outside this block, supplies strobes for start, repeated start and stop conditions and a strobe for each received byte. The matcher compares the address bytes that follow a start against a programmed own address. It works in either a 7-bit or a 10-bit addressing mode. For each byte it accepts, it reports an acknowledge decision one cycle later.

Accepted address bytes and received write data go into a receive register and raise a buffer-full flag. A 10-bit read is allowed only through a repeated start that follows a complete two-byte match. The block also keeps two bits used by the master side: an acknowledge-status bit that records the last sampled ACK/NACK, and a bus-collision flag. The collision flag can be cleared only by a write to the whole status word.

Top module: `i2c_addr_match`

## Requirements
- R1: In 7-bit mode, the first byte after a start or repeated start is acknowledged when bits [7:1] equal own address bits [6:0]. `ack_vld` pulses one cycle after the byte strobe, with `ack_out` giving the decision. Bit 0 = 0 selects receive and bit 0 = 1 selects transmit (`tx_sel`). A mismatch gives a NACK and returns to idle.
- R2: In 7-bit mode, a first byte whose bits [7:4] are 0000 or 1111 is never acknowledged, even when it equals the own address.
- R3: In 10-bit mode, after a start, the header byte 11110 A9 A8 0 is acknowledged. A following byte that equals own address bits [7:0] is acknowledged and the slave becomes addressed for receive.
- R4: The 10-bit low-byte compare is exact over all 8 bits. This includes values such as 0000xxxx and 1111xxxx. A low byte that differs, even when A9/A8 match, gives a NACK and returns to idle.
- R5: Every acknowledged byte (address or receive data) loads `rx_data` and sets `rx_full`. `rx_rd` clears `rx_full`; a load in the same cycle wins.
- R6: A 10-bit header with bit 0 = 1 is acknowledged, and `tx_sel` set, only after a repeated start that follows a full 10-bit match. After a plain start it is not acknowledged.
- R7: A stop returns the matcher to idle and invalidates a previous 10-bit match. Bytes received while idle produce no `ack_vld` and load nothing.
- R8: `ack_stat` takes the value of `ack_smp_nack` on each `ack_smp_vld` and is unchanged by start, repeated start or stop.
- R9: `coll_evt` sets `bus_coll`. It is cleared only by a status write with all byte enables set and status bit 10 = 0. A partial write has no effect. A collision in the same cycle wins.
- R10: A 10-bit header with bit 0 = 0 after a repeated start restarts the two-byte match and invalidates the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Start condition strobe |
| bus_rstart | input | 1 | Repeated start strobe |
| bus_stop | input | 1 | Stop condition strobe |
| rx_byte_vld | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte, MSB first on the wire |
| own_addr | input | 10 | Programmed slave address |
| ten_bit_mode | input | 1 | 1 = 10-bit addressing |
| ack_smp_vld | input | 1 | Master-side ACK sample strobe |
| ack_smp_nack | input | 1 | Sampled bit was a NACK |
| coll_evt | input | 1 | Bus collision detected |
| stat_we | input | 1 | Status word write strobe |
| stat_be | input | 2 | Status write byte enables |
| stat_wdata | input | 16 | Status write data, bit 10 = collision |
| rx_rd | input | 1 | Receive register read, clears full flag |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack_out | output | 1 | 1 = ACK, 0 = NACK |
| rx_data | output | 8 | Receive register |
| rx_full | output | 1 | Receive buffer full |
| tx_sel | output | 1 | Addressed for slave transmit |
| addressed | output | 1 | Addressed (receive or transmit) |
| ack_stat | output | 1 | Last sampled NACK status |
| bus_coll | output | 1 | Bus collision flag |

## Verification
The assertions check the following on every cycle:
- a stop always leaves the matcher idle with no valid 10-bit match;
- every acknowledge pulse follows a byte strobe;
- entry into 10-bit transmit requires a live match;
- the acknowledge-status bit and the collision flag hold unless their own update conditions occur.

Only the bench scenarios can show the address decisions themselves. These include exact low-byte matching for reserved-looking patterns, rejection of a read header after a plain start, the restart of matching by a write header after a repeated start, and the 7-bit reserved-address filter. A behavioural model compares every output each cycle across these sequences.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_HDR  = 3'd1,
      PH_LOW  = 3'd2,
      PH_RX   = 3'd3,
      PH_TX   = 3'd4
   } am_phase_t;

   localparam logic [4:0] TEN_BIT_TAG = 5'b11110;
endpackage

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp #(
   parameter int BYTE_W     = 8,
   parameter int ADDR_W     = 10,
   parameter bit RSV_FILTER = 1'b1
) (
   input  logic [BYTE_W-1:0] byte_in,
   input  logic [ADDR_W-1:0] own_addr,
   output logic              hit7,
   output logic              hdr_hit,
   output logic              low_hit,
   output logic              rw
);
   import i2c_am_pkg::*;

   localparam int UP_W = ADDR_W - BYTE_W;

   logic hit7_raw;
   logic rsv_pat;

   generate
      if (ADDR_W != BYTE_W + 2) begin : g_bad_width
         $error("ADDR_W must be BYTE_W + 2");
      end
   endgenerate

   assign hit7_raw = (byte_in[BYTE_W-1:1] == own_addr[BYTE_W-2:0]);
   assign rsv_pat  = (byte_in[BYTE_W-1:BYTE_W-4] == 4'h0) ||
                     (byte_in[BYTE_W-1:BYTE_W-4] == 4'hF);

   generate
      if (RSV_FILTER) begin : g_filter
         assign hit7 = hit7_raw & ~rsv_pat;
      end else begin : g_nofilter
         assign hit7 = hit7_raw;
      end
   endgenerate

   assign hdr_hit = (byte_in[BYTE_W-1:3] == TEN_BIT_TAG) &&
                    (byte_in[UP_W:1] == own_addr[ADDR_W-1:BYTE_W]);
   assign low_hit = (byte_in == own_addr[BYTE_W-1:0]);
   assign rw      = byte_in[0];
endmodule

// File: rtl/i2c_am_fsm.sv
module i2c_am_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_start,
   input  logic bus_rstart,
   input  logic bus_stop,
   input  logic byte_vld,
   input  logic mode10,
   input  logic hit7,
   input  logic hdr_hit,
   input  logic low_hit,
   input  logic rw,
   output logic load,
   output logic ack_vld,
   output logic ack_out,
   output logic tx_sel,
   output logic addressed
);
   import i2c_am_pkg::*;

   am_phase_t ph, ph_nxt;
   logic      ten_ok, ten_nxt;
   logic      takes, acc;

   always_comb begin
      ph_nxt  = ph;
      ten_nxt = ten_ok;
      takes   = 1'b0;
      acc     = 1'b0;
      if (bus_stop) begin
         ph_nxt  = PH_IDLE;
         ten_nxt = 1'b0;
      end else if (bus_start) begin
         ph_nxt  = PH_HDR;
         ten_nxt = 1'b0;
      end else if (bus_rstart) begin
         ph_nxt  = PH_HDR;
      end else if (byte_vld) begin
         case (ph)
            PH_HDR: begin
               takes = 1'b1;
               if (!mode10) begin
                  acc    = hit7;
                  ph_nxt = hit7 ? (rw ? PH_TX : PH_RX) : PH_IDLE;
               end else if (hdr_hit && !rw) begin
                  acc     = 1'b1;
                  ph_nxt  = PH_LOW;
                  ten_nxt = 1'b0;
               end else if (hdr_hit && rw && ten_ok) begin
                  acc    = 1'b1;
                  ph_nxt = PH_TX;
               end else begin
                  ph_nxt  = PH_IDLE;
                  ten_nxt = 1'b0;
               end
            end
            PH_LOW: begin
               takes   = 1'b1;
               acc     = low_hit;
               ph_nxt  = low_hit ? PH_RX : PH_IDLE;
               ten_nxt = low_hit;
            end
            PH_RX: begin
               takes = 1'b1;
               acc   = 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= PH_IDLE;
         ten_ok  <= 1'b0;
         ack_vld <= 1'b0;
         ack_out <= 1'b0;
      end else begin
         ph      <= ph_nxt;
         ten_ok  <= ten_nxt;
         ack_vld <= takes;
         ack_out <= takes & acc;
      end
   end

   assign load      = takes & acc;
   assign tx_sel    = (ph == PH_TX);
   assign addressed = (ph == PH_RX) || (ph == PH_TX);

   // R7
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stop |=> (ph == PH_IDLE) && !ten_ok);
   // R1
   ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_vld |-> $past(byte_vld));
   // R1
   ack_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_out |-> ack_vld);
   // R6
   tx_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tx_sel) && $past(mode10)) |-> $past(ten_ok));
endmodule

// File: rtl/i2c_am_flags.sv
module i2c_am_flags #(
   parameter int BYTE_W  = 8,
   parameter int STAT_W  = 16,
   parameter int BCL_BIT = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [BYTE_W-1:0]     byte_in,
   input  logic                  rx_rd,
   input  logic                  ack_smp_vld,
   input  logic                  ack_smp_nack,
   input  logic                  coll_evt,
   input  logic                  stat_we,
   input  logic [STAT_W/8-1:0]   stat_be,
   input  logic [STAT_W-1:0]     stat_wdata,
   output logic [BYTE_W-1:0]     rx_data,
   output logic                  rx_full,
   output logic                  ack_stat,
   output logic                  bus_coll
);
   logic full_wr;
   logic unused_wdata;

   generate
      if (BCL_BIT >= STAT_W) begin : g_bad_bcl
         $error("BCL_BIT outside the status word");
      end
      if (STAT_W % 8 != 0) begin : g_bad_stat
         $error("STAT_W must be a whole number of bytes");
      end
   endgenerate

   assign full_wr      = stat_we && (&stat_be);
   assign unused_wdata = ^stat_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data  <= '0;
         rx_full  <= 1'b0;
         ack_stat <= 1'b0;
         bus_coll <= 1'b0;
      end else begin
         if (load) begin
            rx_data <= byte_in;
            rx_full <= 1'b1;
         end else if (rx_rd) begin
            rx_full <= 1'b0;
         end
         if (ack_smp_vld) ack_stat <= ack_smp_nack;
         if (coll_evt) bus_coll <= 1'b1;
         else if (full_wr && !stat_wdata[BCL_BIT]) bus_coll <= 1'b0;
      end
   end

   // R8
   ackstat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_smp_vld |=> $stable(ack_stat));
   // R9
   bcl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!coll_evt && !(stat_we && (&stat_be))) |=> $stable(bus_coll));
   // R9
   bcl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      coll_evt |=> bus_coll);
   // R5
   rbf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd && !load) |=> !rx_full);
   // R5
   rbf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> rx_full && (rx_data == $past(byte_in)));
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
   parameter int BYTE_W     = 8,
   parameter int ADDR_W     = 10,
   parameter int STAT_W     = 16,
   parameter int BCL_BIT    = 10,
   parameter bit RSV_FILTER = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_start,
   input  logic                bus_rstart,
   input  logic                bus_stop,
   input  logic                rx_byte_vld,
   input  logic [BYTE_W-1:0]   rx_byte,
   input  logic [ADDR_W-1:0]   own_addr,
   input  logic                ten_bit_mode,
   input  logic                ack_smp_vld,
   input  logic                ack_smp_nack,
   input  logic                coll_evt,
   input  logic                stat_we,
   input  logic [STAT_W/8-1:0] stat_be,
   input  logic [STAT_W-1:0]   stat_wdata,
   input  logic                rx_rd,
   output logic                ack_vld,
   output logic                ack_out,
   output logic [BYTE_W-1:0]   rx_data,
   output logic                rx_full,
   output logic                tx_sel,
   output logic                addressed,
   output logic                ack_stat,
   output logic                bus_coll
);
   logic hit7, hdr_hit, low_hit, rw, load;

   i2c_am_cmp #(
      .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .RSV_FILTER(RSV_FILTER)
   ) u_cmp (
      .byte_in(rx_byte), .own_addr(own_addr),
      .hit7(hit7), .hdr_hit(hdr_hit), .low_hit(low_hit), .rw(rw)
   );

   i2c_am_fsm u_fsm (
      .clk(clk), .rst_n(rst_n),
      .bus_start(bus_start), .bus_rstart(bus_rstart), .bus_stop(bus_stop),
      .byte_vld(rx_byte_vld), .mode10(ten_bit_mode),
      .hit7(hit7), .hdr_hit(hdr_hit), .low_hit(low_hit), .rw(rw),
      .load(load), .ack_vld(ack_vld), .ack_out(ack_out),
      .tx_sel(tx_sel), .addressed(addressed)
   );

   i2c_am_flags #(
      .BYTE_W(BYTE_W), .STAT_W(STAT_W), .BCL_BIT(BCL_BIT)
   ) u_flags (
      .clk(clk), .rst_n(rst_n), .load(load), .byte_in(rx_byte),
      .rx_rd(rx_rd), .ack_smp_vld(ack_smp_vld), .ack_smp_nack(ack_smp_nack),
      .coll_evt(coll_evt), .stat_we(stat_we), .stat_be(stat_be),
      .stat_wdata(stat_wdata), .rx_data(rx_data), .rx_full(rx_full),
      .ack_stat(ack_stat), .bus_coll(bus_coll)
   );
endmodule

// File: tb/sim_i2c_addr_match.sv
module sim_i2c_addr_match;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_start = 0, bus_rstart = 0, bus_stop = 0;
   logic        rx_byte_vld = 0;
   logic [7:0]  rx_byte = 0;
   logic [9:0]  own_addr = 0;
   logic        ten_bit_mode = 0;
   logic        ack_smp_vld = 0, ack_smp_nack = 0, coll_evt = 0;
   logic        stat_we = 0;
   logic [1:0]  stat_be = 0;
   logic [15:0] stat_wdata = 0;
   logic        rx_rd = 0;
   logic        ack_vld, ack_out, rx_full, tx_sel, addressed, ack_stat, bus_coll;
   logic [7:0]  rx_data;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   i2c_addr_match u0 (
      .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_rstart(bus_rstart),
      .bus_stop(bus_stop), .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
      .own_addr(own_addr), .ten_bit_mode(ten_bit_mode), .ack_smp_vld(ack_smp_vld),
      .ack_smp_nack(ack_smp_nack), .coll_evt(coll_evt), .stat_we(stat_we),
      .stat_be(stat_be), .stat_wdata(stat_wdata), .rx_rd(rx_rd),
      .ack_vld(ack_vld), .ack_out(ack_out), .rx_data(rx_data), .rx_full(rx_full),
      .tx_sel(tx_sel), .addressed(addressed), .ack_stat(ack_stat), .bus_coll(bus_coll)
   );

   task automatic chk(input string req, input string nm, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, nm, act, exp, $time);
      end
   endtask

   // reference model: phase 0 idle, 1 header, 2 low byte, 3 receive, 4 transmit
   int   m_ph = 0;
   bit   m_ten = 0, m_ackv = 0, m_ack = 0, m_full = 0, m_as = 0, m_bc = 0;
   bit   m_ok = 0, m_take = 0, m_hdr = 0;
   logic [7:0] m_rx = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_ten = 0; m_ackv = 0; m_ack = 0; m_full = 0;
         m_as = 0; m_bc = 0; m_rx = 0;
      end else begin
         m_ok = 0; m_take = 0;
         if (ack_smp_vld) m_as = ack_smp_nack;
         if (coll_evt) m_bc = 1;
         else if (stat_we && stat_be == 2'b11 && !stat_wdata[10]) m_bc = 0;
         if (rx_rd) m_full = 0;
         if (bus_stop) begin m_ph = 0; m_ten = 0; end
         else if (bus_start) begin m_ph = 1; m_ten = 0; end
         else if (bus_rstart) m_ph = 1;
         else if (rx_byte_vld && m_ph >= 1 && m_ph <= 3) begin
            m_take = 1;
            if (m_ph == 3) m_ok = 1;
            else if (m_ph == 2) begin
               m_ok = (rx_byte == own_addr[7:0]);
               m_ph = m_ok ? 3 : 0;
               m_ten = m_ok;
            end else if (!ten_bit_mode) begin
               m_ok = (rx_byte[7:1] == own_addr[6:0]) &&
                      rx_byte[7:4] != 4'h0 && rx_byte[7:4] != 4'hF;
               m_ph = m_ok ? (rx_byte[0] ? 4 : 3) : 0;
            end else begin
               m_hdr = (rx_byte[7:3] == 5'b11110) && (rx_byte[2:1] == own_addr[9:8]);
               if (m_hdr && !rx_byte[0]) begin m_ok = 1; m_ph = 2; m_ten = 0; end
               else if (m_hdr && m_ten) begin m_ok = 1; m_ph = 4; end
               else begin m_ph = 0; m_ten = 0; end
            end
            if (m_ok) begin m_rx = rx_byte; m_full = 1; end
         end
         m_ackv = m_take;
         m_ack = m_take & m_ok;
      end
      #1;
      if (rst_n) begin
         chk("R1", "ack_vld", ack_vld, m_ackv);
         chk("R1", "ack_out", ack_out, m_ack);
         chk("R5", "rx_data", rx_data, m_rx);
         chk("R5", "rx_full", rx_full, m_full);
         chk("R6", "tx_sel", tx_sel, m_ph == 4);
         chk("R7", "addressed", addressed, m_ph == 3 || m_ph == 4);
         chk("R8", "ack_stat", ack_stat, m_as);
         chk("R9", "bus_coll", bus_coll, m_bc);
      end
   end

   task automatic t_start();  @(negedge clk); bus_start = 1;  @(negedge clk); bus_start = 0;  endtask
   task automatic t_rstart(); @(negedge clk); bus_rstart = 1; @(negedge clk); bus_rstart = 0; endtask
   task automatic t_stop();   @(negedge clk); bus_stop = 1;   @(negedge clk); bus_stop = 0;   endtask
   task automatic t_byte(input logic [7:0] b, input bit rd);
      @(negedge clk); rx_byte_vld = 1; rx_byte = b; rx_rd = rd;
      @(negedge clk); rx_byte_vld = 0; rx_rd = 0;
   endtask
   task automatic t_rd(); @(negedge clk); rx_rd = 1; @(negedge clk); rx_rd = 0; endtask
   task automatic t_acks(input bit n);
      @(negedge clk); ack_smp_vld = 1; ack_smp_nack = n;
      @(negedge clk); ack_smp_vld = 0;
   endtask
   task automatic t_coll(); @(negedge clk); coll_evt = 1; @(negedge clk); coll_evt = 0; endtask
   task automatic t_swr(input logic [1:0] be, input logic [15:0] d);
      @(negedge clk); stat_we = 1; stat_be = be; stat_wdata = d;
      @(negedge clk); stat_we = 0;
   endtask

   initial begin
      #100000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state
      chk("R5", "reset rx_full", rx_full, 0);
      chk("R7", "reset addressed", addressed, 0);
      chk("R9", "reset bus_coll", bus_coll, 0);

      // 7-bit write, data, read-clear, stop
      own_addr = 10'h03A;
      t_start(); t_byte({7'h3A, 1'b0}, 0);
      chk("R1", "7b match ack", ack_out, 1);
      chk("R1", "7b write rx", tx_sel, 0);
      t_byte(8'h99, 0);
      chk("R5", "data loaded", rx_data, 8'h99);
      t_rd();
      chk("R5", "rd clears full", rx_full, 0);
      t_byte(8'h42, 1);
      chk("R5", "load beats rd", rx_full, 1);
      t_stop();
      chk("R7", "stop idle", addressed, 0);
      t_byte(8'h11, 0);
      chk("R7", "idle byte no ack", ack_vld, 0);
      chk("R7", "idle byte no load", rx_data, 8'h42);

      // 7-bit mismatch and read
      t_start(); t_byte({7'h3B, 1'b0}, 0);
      chk("R1", "7b mismatch nack", ack_out, 0);
      chk("R1", "7b mismatch vld", ack_vld, 1);
      t_start(); t_byte({7'h3A, 1'b1}, 0);
      chk("R1", "7b read tx", tx_sel, 1);
      t_stop();

      // reserved 7-bit address never acked
      own_addr = 10'h005;
      t_start(); t_byte({7'h05, 1'b0}, 0);
      chk("R2", "reserved nack", ack_out, 0);
      own_addr = 10'h07C;
      t_start(); t_byte({7'h7C, 1'b0}, 0);
      chk("R2", "reserved 1111 nack", ack_out, 0);
      t_stop();

      // 10-bit match with reserved-looking low byte
      ten_bit_mode = 1; own_addr = 10'h205;
      t_start(); t_byte(8'hF4, 0);
      chk("R3", "hdr ack", ack_out, 1);
      t_byte(8'h05, 0);
      chk("R4", "low 0000 pattern ack", ack_out, 1);
      chk("R3", "low loaded", rx_data, 8'h05);
      chk("R3", "addressed rx", addressed, 1);
      t_rstart(); t_byte(8'hF5, 0);
      chk("R6", "read after rstart ack", ack_out, 1);
      chk("R6", "read tx", tx_sel, 1);
      t_stop();

      // read header after plain start
      t_start(); t_byte(8'hF5, 0);
      chk("R6", "read after start nack", ack_out, 0);

      // neighbour sharing upper bits
      t_start(); t_byte(8'hF4, 0); t_byte(8'h06, 0);
      chk("R4", "other low byte nack", ack_out, 0);
      chk("R4", "other low byte idle", addressed, 0);

      // low byte 1111 pattern
      own_addr = 10'h2F3;
      t_start(); t_byte(8'hF4, 0); t_byte(8'hF3, 0);
      chk("R4", "low 1111 pattern ack", ack_out, 1);
      chk("R4", "low 1111 loaded", rx_data, 8'hF3);

      // write header after rstart restarts the match
      t_rstart(); t_byte(8'hF4, 0);
      chk("R10", "rstart write hdr ack", ack_out, 1);
      t_rstart(); t_byte(8'hF5, 0);
      chk("R10", "match invalidated", ack_out, 0);
      t_stop();

      // acknowledge status
      t_acks(1);
      chk("R8", "nack recorded", ack_stat, 1);
      t_start(); t_stop(); t_rstart();
      chk("R8", "kept over start/stop", ack_stat, 1);
      t_acks(0);
      chk("R8", "ack recorded", ack_stat, 0);

      // collision flag
      t_coll();
      chk("R9", "coll set", bus_coll, 1);
      t_swr(2'b01, 16'h0000);
      chk("R9", "partial write ignored", bus_coll, 1);
      t_swr(2'b11, 16'h0400);
      chk("R9", "write one keeps", bus_coll, 1);
      t_swr(2'b11, 16'h0000);
      chk("R9", "full write clears", bus_coll, 0);

      repeat (3) @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule